// File: doc/BRIEF.md
# Block Output Transfer Sequencer

This block carries out the four block-output operations of an 8-bit processor: a single transfer that steps the pointer upward, a single transfer that steps it downward, and a repeating form of each. Every transfer reads one byte from memory at the 16-bit pointer HL and writes that byte to the I/O port selected by register C. After the write, the pointer is stepped, the count register B is decremented and the whole flag byte is rewritten. That includes the undocumented half-carry, carry, subtract and parity results, which are derived from the moved byte and the new low pointer byte.

The surrounding core loads B, C and HL through a load strobe while the block is idle. It then pulses `start` with a 2-bit operation select. Bit 0 of the select picks the direction (0 = increment, 1 = decrement) and bit 1 picks the repeating form. The block uses a request/acknowledge handshake for the memory read and another for the I/O write, and waits for each acknowledge before it moves on. At the end it raises `done` for one cycle. It also reports the T-state cost of the instruction: 16 per transfer, plus 5 for every transfer after which the repeating form goes round again.

Top module: `block_out_seq`

## Requirements
- R1: After reset, B, C, HL, the flag byte and the T-state count are all zero, and busy, done, memReq and ioReq are low.
- R2: Each transfer raises memReq with memAddr equal to the current HL and holds both until memAck is seen; the transfers read HL, HL±1, ... in order.
- R3: Each transfer then raises ioReq, with ioData equal to the byte read and ioAddr = {B-1, C}, and holds it until ioAck. memReq and ioReq are never high together.
- R4: After each transfer HL becomes HL+1 when opSel[0]=0 and HL-1 when opSel[0]=1, wrapping modulo 2^16; C is never changed.
- R5: B decrements by one per transfer, wrapping from 0x00 to 0xFF. Flag bit 7 (S) equals bit 7 of the new B, and flag bit 6 (Z) is set exactly when the new B is zero.
- R6: Flag bit 1 (N) equals bit 7 of the transferred byte. Flag bits 4 (H) and 0 (C) both equal the carry out of the 8-bit sum of the new L and the byte.
- R7: Flag bit 2 (P/V) is set when ((L_new + byte) & 7) XOR B_new has an even number of ones. Flag bits 5 and 3 read zero.
- R8: A single form (opSel[1]=0) does exactly one transfer, reports 16 T-states and pulses done for one cycle, after which busy is low.
- R9: A repeating form (opSel[1]=1) repeats while the new B is nonzero. n transfers report 21·n − 5 T-states.
- R10: A repeating form started with B=0 performs 256 transfers and reports 5371 T-states.
- R11: start and the register load strobe have no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load B, C, HL from the load inputs (idle only) |
| loadB | input | 8 | Value for B |
| loadC | input | 8 | Value for C |
| loadHL | input | 16 | Value for HL |
| start | input | 1 | Begin an operation (idle only) |
| opSel | input | 2 | bit0 direction (1 = decrement), bit1 repeat |
| memReq | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memAck | input | 1 | Memory read acknowledge, data valid |
| memData | input | 8 | Memory read data |
| ioReq | output | 1 | I/O write request |
| ioAddr | output | 16 | I/O port address |
| ioData | output | 8 | I/O write data |
| ioAck | input | 1 | I/O write acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| regB | output | 8 | Count register |
| regC | output | 8 | Port register |
| regHL | output | 16 | Pointer register |
| flags | output | 8 | Flag byte {S,Z,0,H,0,P/V,N,C} |
| tStates | output | 16 | T-state cost of the last operation |

## Verification
Every low pointer byte from 0 to 255 is run through a single transfer, with the count varied alongside it. This sweeps the carry, parity and sign outcomes, so an error in the flag arithmetic or in the choice of old versus new L shows up. All four operations are run with counts 0, 1, 2, 3, 0x80 and 0x81 and with pointers that sit on page and 16-bit wrap boundaries. These runs separate the increment path from the decrement path, the stop on a zero count from an early exit or a missed repeat, and the 256-transfer wrap. Acknowledge delays of zero to two cycles are mixed in so that a sequencer that ignores the handshake is caught. One run pulses start and the load strobe in the middle of an operation to show they change nothing.

// File: rtl/bos_pkg.sv
package bos_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_STEP  = 3'd3,
    ST_FIN   = 3'd4
  } seqState_t;

  typedef struct packed {
    logic loadRegs;
    logic clearT;
    logic captureByte;
    logic stepRegs;
    logic goAgain;
    logic decDir;
  } seqStrobe_t;
endpackage

// File: rtl/bos_control.sv
module bos_control
  import bos_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       start,
  input  logic [1:0] opSel,
  input  logic       memAck,
  input  logic       ioAck,
  input  logic       bNextZero,
  output logic       memReq,
  output logic       ioReq,
  output logic       busy,
  output logic       done,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;
  logic      dirDec;
  logic      repeatMode;
  logic      idle;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      dirDec     <= 1'b0;
      repeatMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (idle && start) begin
        dirDec     <= opSel[0];
        repeatMode <= opSel[1];
      end
    end
  end

  always_comb begin
    stateNext          = state;
    strobe             = '0;
    strobe.decDir      = dirDec;
    strobe.loadRegs    = idle && loadEn;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clearT = 1'b1;
          stateNext     = ST_READ;
        end
      end
      ST_READ: begin
        if (memAck) begin
          strobe.captureByte = 1'b1;
          stateNext          = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (ioAck) stateNext = ST_STEP;
      end
      ST_STEP: begin
        strobe.stepRegs = 1'b1;
        strobe.goAgain  = repeatMode && !bNextZero;
        stateNext       = strobe.goAgain ? ST_READ : ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_READ);
  assign ioReq  = (state == ST_WRITE);
  assign busy   = !idle;
  assign done   = (state == ST_FIN);
endmodule

// File: rtl/bos_datapath.sv
module bos_datapath
  import bos_pkg::*;
#(
  parameter int TS_W     = 16,
  parameter int T_STEP   = 16,
  parameter int T_REPEAT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadB,
  input  logic [DATA_W-1:0] loadC,
  input  logic [ADDR_W-1:0] loadHL,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] ioData,
  output logic              bNextZero,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic [ADDR_W-1:0] regHL,
  output logic [7:0]        flags,
  output logic [TS_W-1:0]   tStates
);
  logic [DATA_W-1:0] byteReg;
  logic [DATA_W-1:0] bNext;
  logic [ADDR_W-1:0] hlNext;
  logic [DATA_W:0]   lSum;
  logic [DATA_W-1:0] parityVec;
  logic [7:0]        flagsNext;
  logic [TS_W-1:0]   tAdd;

  assign bNext     = regB - 1'b1;
  assign bNextZero = (bNext == '0);
  assign hlNext    = strobe.decDir ? (regHL - 1'b1) : (regHL + 1'b1);
  assign lSum      = {1'b0, hlNext[DATA_W-1:0]} + {1'b0, byteReg};
  assign parityVec = {bNext[DATA_W-1:3], bNext[2:0] ^ lSum[2:0]};

  always_comb begin
    flagsNext          = '0;
    flagsNext[FLAG_S]  = bNext[DATA_W-1];
    flagsNext[FLAG_Z]  = bNextZero;
    flagsNext[FLAG_H]  = lSum[DATA_W];
    flagsNext[FLAG_PV] = ~^parityVec;
    flagsNext[FLAG_N]  = byteReg[DATA_W-1];
    flagsNext[FLAG_C]  = lSum[DATA_W];
  end

  assign tAdd = strobe.goAgain ? TS_W'(T_STEP + T_REPEAT) : TS_W'(T_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regB    <= '0;
      regC    <= '0;
      regHL   <= '0;
      flags   <= '0;
      byteReg <= '0;
      tStates <= '0;
    end else begin
      if (strobe.loadRegs) begin
        regB  <= loadB;
        regC  <= loadC;
        regHL <= loadHL;
      end
      if (strobe.clearT)      tStates <= '0;
      if (strobe.captureByte) byteReg <= memData;
      if (strobe.stepRegs) begin
        regB    <= bNext;
        regHL   <= hlNext;
        flags   <= flagsNext;
        tStates <= tStates + tAdd;
      end
    end
  end

  assign memAddr = regHL;
  assign ioAddr  = {bNext, regC};
  assign ioData  = byteReg;
endmodule

// File: rtl/block_out_seq.sv
module block_out_seq
  import bos_pkg::*;
#(
  parameter int TS_W     = 16,
  parameter int T_STEP   = 16,
  parameter int T_REPEAT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic [7:0]  loadB,
  input  logic [7:0]  loadC,
  input  logic [15:0] loadHL,
  input  logic        start,
  input  logic [1:0]  opSel,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        ioReq,
  output logic [15:0] ioAddr,
  output logic [7:0]  ioData,
  input  logic        ioAck,
  output logic        busy,
  output logic        done,
  output logic [7:0]  regB,
  output logic [7:0]  regC,
  output logic [15:0] regHL,
  output logic [7:0]  flags,
  output logic [TS_W-1:0] tStates
);
  seqStrobe_t strobe;
  logic       bNextZero;

  bos_control u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .start(start), .opSel(opSel),
    .memAck(memAck), .ioAck(ioAck), .bNextZero(bNextZero),
    .memReq(memReq), .ioReq(ioReq), .busy(busy), .done(done), .strobe(strobe)
  );

  bos_datapath #(.TS_W(TS_W), .T_STEP(T_STEP), .T_REPEAT(T_REPEAT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadB(loadB), .loadC(loadC), .loadHL(loadHL), .memData(memData),
    .memAddr(memAddr), .ioAddr(ioAddr), .ioData(ioData), .bNextZero(bNextZero),
    .regB(regB), .regC(regC), .regHL(regHL), .flags(flags), .tStates(tStates)
  );
endmodule

// File: rtl/block_out_seq_chk.sv
module block_out_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        memReq,
  input logic [15:0] memAddr,
  input logic        memAck,
  input logic        ioReq,
  input logic [15:0] ioAddr,
  input logic        ioAck,
  input logic [7:0]  regC
);
  // R3
  no_req_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && ioReq));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R3
  io_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioAck) |=> (ioReq && $stable(ioAddr)));

  // R3
  io_port_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioReq |-> (ioAddr[7:0] == regC));

  // R8
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind block_out_seq block_out_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
  .ioReq(ioReq), .ioAddr(ioAddr), .ioAck(ioAck), .regC(regC)
);

// File: tb/block_out_seq_bench.sv
module block_out_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, loadEn, start, memAck, ioAck;
  logic [7:0]  loadB, loadC, memData;
  logic [15:0] loadHL;
  logic [1:0]  opSel;
  logic        memReq, ioReq, busy, done;
  logic [15:0] memAddr, ioAddr, regHL, tStates;
  logic [7:0]  ioData, regB, regC, flags;

  block_out_seq u_block_out_seq (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadB(loadB), .loadC(loadC),
    .loadHL(loadHL), .start(start), .opSel(opSel),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .ioReq(ioReq), .ioAddr(ioAddr), .ioData(ioData), .ioAck(ioAck),
    .busy(busy), .done(done), .regB(regB), .regC(regC), .regHL(regHL),
    .flags(flags), .tStates(tStates)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int seed = 0;
  int memWait = 0;
  int ioWait = 0;
  int memCount = 0;
  int ioCount = 0;
  logic [15:0] memLog [300];
  logic [15:0] ioAddrLog [300];
  logic [7:0]  ioDataLog [300];

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h47;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory and I/O responders with 0..2 cycle acknowledge delay
  initial begin
    memAck = 0; ioAck = 0; memData = '0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 0;
      else if (memReq) begin
        if (memWait > 0) memWait--;
        else begin
          memAck = 1;
          memData = memByte(memAddr);
          if (memCount < 300) memLog[memCount] = memAddr;
          memCount++;
          memWait = seed % 3; seed++;
        end
      end
      if (ioAck) ioAck = 0;
      else if (ioReq) begin
        if (ioWait > 0) ioWait--;
        else begin
          ioAck = 1;
          if (ioCount < 300) begin
            ioAddrLog[ioCount] = ioAddr;
            ioDataLog[ioCount] = ioData;
          end
          ioCount++;
          ioWait = (seed * 7) % 3; seed++;
        end
      end
    end
  end

  task automatic runOp(input logic [1:0] op, input logic [7:0] b,
                       input logic [7:0] c, input logic [15:0] hl,
                       input bit disturb);
    int n;
    int cyc;
    int logErr;
    logic [7:0]  eb, byteV, lNew, pvVec, eFlags;
    logic [8:0]  sum;
    logic [15:0] ehl;
    int eT;
    memCount = 0; ioCount = 0;
    @(negedge clk);
    loadEn = 1; loadB = b; loadC = c; loadHL = hl;
    @(negedge clk);
    loadEn = 0; start = 1; opSel = op;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      // R11: start and load while busy must change nothing
      start = 1; opSel = ~op; loadEn = 1; loadB = 8'h55; loadC = ~c; loadHL = ~hl;
      @(negedge clk);
      start = 0; loadEn = 0;
    end
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    check(done, "R8", "done seen", done, 1);
    n = op[1] ? ((b == 0) ? 256 : int'(b)) : 1;
    eb = b; ehl = hl; logErr = 0; eFlags = '0;
    for (int i = 0; i < n; i++) begin
      byteV = memByte(ehl);
      if (i < 300) begin
        if (memLog[i] != ehl) logErr++;
        if (ioAddrLog[i] != {eb - 8'd1, c}) logErr++;
        if (ioDataLog[i] != byteV) logErr++;
      end
      ehl = op[0] ? ehl - 16'd1 : ehl + 16'd1;
      eb = eb - 8'd1;
      lNew = ehl[7:0];
      sum = {1'b0, lNew} + {1'b0, byteV};
      pvVec = {eb[7:3], eb[2:0] ^ sum[2:0]};
      eFlags = {eb[7], (eb == 0), 1'b0, sum[8], 1'b0, ~^pvVec, byteV[7], sum[8]};
    end
    eT = op[1] ? 21 * n - 5 : 16;
    check(logErr == 0, "R2/R3", "transfer log mismatches", logErr, 0);
    check(ioCount == n, op[1] ? (b == 0 ? "R10" : "R9") : "R8", "transfer count", ioCount, n);
    check(int'(tStates) == eT, op[1] ? (b == 0 ? "R10" : "R9") : "R8", "T-states", tStates, eT);
    check(regHL == ehl && regC == c, "R4", "HL", regHL, ehl);
    check(regB == eb && flags[7:6] == eFlags[7:6], "R5", "B/S/Z", {regB, flags[7:6]}, {eb, eFlags[7:6]});
    check(flags[4] == eFlags[4] && flags[1:0] == eFlags[1:0], "R6", "N/H/C",
          flags, eFlags);
    check(flags[2] == eFlags[2] && flags[5] == 0 && flags[3] == 0, "R7", "P/V", flags, eFlags);
    @(negedge clk);
    check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    #4000000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0]  bList [6];
    logic [15:0] hList [4];
    bList = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80, 8'h81};
    hList = '{16'h0000, 16'hFFFF, 16'h12FF, 16'h8A40};
    rstN = 0; loadEn = 0; start = 0; opSel = 0;
    loadB = 0; loadC = 0; loadHL = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check(regB == 0 && regC == 0 && regHL == 0 && flags == 0 && tStates == 0,
          "R1", "register reset", {regB, regC, regHL}, 0);
    check(!busy && !done && !memReq && !ioReq, "R1", "control reset",
          {busy, done, memReq, ioReq}, 0);
    // R6 R7: sweep low pointer byte through single transfers
    for (int l = 0; l < 256; l++)
      runOp({1'b0, l[0]}, l[7:0] ^ 8'h5A, l[7:0] + 8'd3, {l[7:0] ^ 8'hC3, l[7:0]}, 1'b0);
    // R4 R5 R9 R10: all operations across counts and pointers
    for (int op = 0; op < 4; op++)
      for (int bi = 0; bi < 6; bi++)
        for (int hi = 0; hi < 4; hi++)
          runOp(op[1:0], bList[bi], 8'h30 + 8'(bi), hList[hi], 1'b0);
    // R11
    runOp(2'b11, 8'h03, 8'h7E, 16'h4000, 1'b1);
    runOp(2'b00, 8'h10, 8'h22, 16'h0100, 1'b1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule